// File: doc/BRIEF.md
# JTAG IDCODE Reader

This sequencer fetches the 32-bit identification code of one device in a JTAG scan chain. It drives TCK, TMS and TDI itself and samples TDO. On a start pulse it latches a device index and resets every TAP. It then measures how many devices sit in the chain: all instruction registers are loaded with ones so that each device selects its one-bit bypass register, the data path is flushed with zeros, and ones are fed in until the first one comes out at TDO.

A second reset makes every device load its IDCODE into its data register. If the index is not below the measured length, the run ends with an error flag and a zero ID. Otherwise the TAP moves to Shift-DR and the sequencer shifts out (index+1) whole 32-bit words, LSB first, with TDI held high and no exit between words. The last word is the result. The TAP then returns to Run-Test/Idle. Device 0 is the device nearest TDO. Every device is assumed to load an IDCODE after reset.

Top module: `jtag_idcode_reader`

## Requirements
- R1: While rst_ni is low, tck_o, busy_o, done_o, bad_index_o and suspect_o are 0 and id_o is zero.
- R2: Each TCK high phase lasts exactly one clock cycle, each low phase lasts at least three. tms_o and tdi_o do not change while tck_o is high. TDO is sampled on the clock edge that raises TCK.
- R3: A start_i pulse is accepted only when busy_o is low, and busy_o is high from the next cycle. A start_i pulse during a run neither restarts it nor changes its index.
- R4: The chain length is the number of TDO zeros seen while ones are fed after a zero flush of MAX_DEV bits, with all instruction registers loaded with ones. The length saturates at MAX_DEV, and the index is checked against it.
- R5: An index greater than or equal to the measured length ends the run with bad_index_o=1, id_o=0 and suspect_o=0, and no data words are read.
- R6: For a valid index, id_o equals the IDCODE of that device. Device 0 is nearest TDO. Each word is taken LSB first from (index+1) consecutive 32-bit words of the post-reset data chain, with TDI at 1 during the read.
- R7: suspect_o is 1 exactly when a valid result has bit 0 equal to 0.
- R8: When done_o is asserted, the chain's TAPs are in Run-Test/Idle, for both valid and invalid indices.
- R9: done_o is a one-cycle pulse with busy_o low. id_o, bad_index_o and suspect_o hold their values until the next run completes.
- R10: With an empty chain (TDO following TDI), the measured length is 0 and every index is rejected.
- R11: A chain whose instruction registers total up to IR_FILL bits is fully placed in bypass for the length measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted while idle |
| index_i | input | IDX_W | Chain position of the wanted device (0 = nearest TDO) |
| tdo_i | input | 1 | Scan data from the chain |
| tck_o | output | 1 | Test clock |
| tms_o | output | 1 | Test mode select |
| tdi_o | output | 1 | Scan data into the chain |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| id_o | output | 32 | Selected IDCODE, zero on error |
| bad_index_o | output | 1 | Index not below measured chain length |
| suspect_o | output | 1 | Returned IDCODE has bit 0 clear |

## Verification
The hardest case to reach is a run where the length measurement and the IDCODE read must agree across an uneven chain. Instruction register lengths differ per device, the combined length sits exactly at IR_FILL, and the index lands on the last device or one past it. The bench drives a behavioural chain of full TAP controllers whose device count, instruction lengths and IDCODEs are drawn from a seeded $urandom. Directed runs cover the empty chain, a full chain at MAX_DEV, a cleared IDCODE bit 0, and a start pulse with a different index arriving mid-run.

// File: rtl/idcode_pkg.sv
package idcode_pkg;
  localparam int unsigned ID_W = 32;

  typedef enum logic [3:0] {
    PH_IDLE, PH_RST1, PH_TO_SIR, PH_IR_FILL, PH_TO_SDR1, PH_FLUSH,
    PH_COUNT, PH_RST2, PH_TO_SDR2, PH_READ, PH_TO_RTI
  } phase_e;

  typedef enum logic [1:0] {E_IDLE, E_LOW, E_HIGH} eng_e;
endpackage

// File: rtl/jtag_bit_engine.sv
module jtag_bit_engine
  import idcode_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic req_tms_i,
  input  logic req_tdi_i,
  input  logic tdo_i,
  output logic tck_o,
  output logic tms_o,
  output logic tdi_o,
  output logic tdo_smp_o,
  output logic ack_o
);
  eng_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= E_IDLE;
      tck_o     <= 1'b0;
      tms_o     <= 1'b1;
      tdi_o     <= 1'b0;
      tdo_smp_o <= 1'b0;
      ack_o     <= 1'b0;
    end else begin
      ack_o <= 1'b0;
      case (st_q)
        E_IDLE: if (req_i) begin
          tms_o <= req_tms_i;
          tdi_o <= req_tdi_i;
          st_q  <= E_LOW;
        end
        E_LOW: begin
          tck_o     <= 1'b1;
          tdo_smp_o <= tdo_i;  // value ahead of the rising edge
          st_q      <= E_HIGH;
        end
        E_HIGH: begin
          tck_o <= 1'b0;
          ack_o <= 1'b1;
          st_q  <= E_IDLE;
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end

  a_r2_tck_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_o |=> !tck_o);
  a_r2_pins_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_o |-> ($stable(tms_o) && $stable(tdi_o)));
  a_r2_req_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (st_q == E_IDLE));
endmodule

// File: rtl/idcode_seq_ctrl.sv
module idcode_seq_ctrl
  import idcode_pkg::*;
#(
  parameter int unsigned MAX_DEV = 8,
  parameter int unsigned IR_FILL = 64,
  localparam int unsigned IDX_W = $clog2(MAX_DEV),
  localparam int unsigned LEN_W = $clog2(MAX_DEV + 1),
  localparam int unsigned CNT_W = $clog2(ID_W * MAX_DEV + IR_FILL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] index_i,
  input  logic             ack_i,
  input  logic             tdo_i,
  output logic             req_o,
  output logic             req_tms_o,
  output logic             req_tdi_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [ID_W-1:0]  id_o,
  output logic             bad_index_o,
  output logic             suspect_o
);
  localparam logic [CNT_W-1:0] C_ZERO  = '0;
  localparam logic [CNT_W-1:0] C_ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_TWO   = CNT_W'(2);
  localparam logic [CNT_W-1:0] C_THREE = CNT_W'(3);
  localparam logic [CNT_W-1:0] C_RST   = CNT_W'(5);
  localparam logic [CNT_W-1:0] C_FILL  = CNT_W'(IR_FILL - 1);
  localparam logic [CNT_W-1:0] C_FLUSH = CNT_W'(MAX_DEV - 1);
  localparam logic [CNT_W-1:0] C_CAP   = CNT_W'(MAX_DEV);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] len_q;
  logic [ID_W-1:0]  sh_q;
  logic             last;
  logic [CNT_W-1:0] rd_last;
  logic             idx_bad;

  assign rd_last = CNT_W'({idx_q, 5'h1f});
  assign idx_bad = LEN_W'(idx_q) >= len_q;
  assign busy_o  = phase_q != PH_IDLE;
  assign req_o   = busy_o && !pend_q;

  always_comb begin
    req_tms_o = 1'b0;
    req_tdi_o = 1'b0;
    last      = 1'b0;
    case (phase_q)
      PH_RST1, PH_RST2: begin
        req_tms_o = cnt_q < C_RST;  // five high, then one low
        last      = cnt_q == C_RST;
      end
      PH_TO_SIR, PH_TO_SDR1: begin
        req_tms_o = cnt_q < C_TWO;  // 1,1,0,0
        last      = cnt_q == C_THREE;
      end
      PH_IR_FILL: begin
        req_tdi_o = 1'b1;
        last      = cnt_q == C_FILL;
        req_tms_o = last;
      end
      PH_FLUSH: last = cnt_q == C_FLUSH;
      PH_COUNT: begin
        req_tdi_o = 1'b1;
        last      = tdo_i || (cnt_q == C_CAP);
      end
      PH_TO_SDR2: begin
        req_tms_o = cnt_q == C_ZERO;  // 1,0,0
        last      = cnt_q == C_TWO;
      end
      PH_READ: begin
        req_tdi_o = 1'b1;
        last      = cnt_q == rd_last;
        req_tms_o = last;
      end
      PH_TO_RTI: begin
        req_tms_o = cnt_q == C_ZERO;  // 1,0
        last      = cnt_q == C_ONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      pend_q      <= 1'b0;
      idx_q       <= '0;
      len_q       <= '0;
      sh_q        <= '0;
      done_o      <= 1'b0;
      id_o        <= '0;
      bad_index_o <= 1'b0;
      suspect_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (start_i) begin
          idx_q   <= index_i;
          phase_q <= PH_RST1;
          cnt_q   <= '0;
          pend_q  <= 1'b0;
        end
      end else if (!pend_q) begin
        pend_q <= 1'b1;
      end else if (ack_i) begin
        pend_q <= 1'b0;
        if (phase_q == PH_READ) sh_q <= {tdo_i, sh_q[ID_W-1:1]};
        if (!last) begin
          cnt_q <= cnt_q + C_ONE;
        end else begin
          cnt_q <= '0;
          case (phase_q)
            PH_RST1:    phase_q <= PH_TO_SIR;
            PH_TO_SIR:  phase_q <= PH_IR_FILL;
            PH_IR_FILL: phase_q <= PH_TO_SDR1;
            PH_TO_SDR1: phase_q <= PH_FLUSH;
            PH_FLUSH:   phase_q <= PH_COUNT;
            PH_COUNT: begin
              len_q   <= LEN_W'(cnt_q);
              phase_q <= PH_RST2;
            end
            PH_RST2: begin
              if (idx_bad) begin
                id_o        <= '0;
                bad_index_o <= 1'b1;
                suspect_o   <= 1'b0;
                done_o      <= 1'b1;
                phase_q     <= PH_IDLE;
              end else begin
                phase_q <= PH_TO_SDR2;
              end
            end
            PH_TO_SDR2: phase_q <= PH_READ;
            PH_READ:    phase_q <= PH_TO_RTI;
            PH_TO_RTI: begin
              id_o        <= sh_q;
              bad_index_o <= 1'b0;
              suspect_o   <= !sh_q[0];
              done_o      <= 1'b1;
              phase_q     <= PH_IDLE;
            end
            default: phase_q <= PH_IDLE;
          endcase
        end
      end
    end
  end

  a_r3_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(idx_q));
  a_r5_no_read_bad_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_READ) |-> (LEN_W'(idx_q) < len_q));
  a_r5_bad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_index_o |-> ((id_o == '0) && !suspect_o));
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/jtag_idcode_reader.sv
module jtag_idcode_reader
  import idcode_pkg::*;
#(
  parameter int unsigned MAX_DEV = 8,
  parameter int unsigned IR_FILL = 64,
  localparam int unsigned IDX_W = $clog2(MAX_DEV)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] index_i,
  input  logic             tdo_i,
  output logic             tck_o,
  output logic             tms_o,
  output logic             tdi_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [ID_W-1:0]  id_o,
  output logic             bad_index_o,
  output logic             suspect_o
);
  logic req, req_tms, req_tdi, ack, tdo_smp;

  idcode_seq_ctrl #(.MAX_DEV(MAX_DEV), .IR_FILL(IR_FILL)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .index_i,
    .ack_i(ack), .tdo_i(tdo_smp),
    .req_o(req), .req_tms_o(req_tms), .req_tdi_o(req_tdi),
    .busy_o, .done_o, .id_o, .bad_index_o, .suspect_o
  );

  jtag_bit_engine u_eng (
    .clk_i, .rst_ni,
    .req_i(req), .req_tms_i(req_tms), .req_tdi_i(req_tdi),
    .tdo_i, .tck_o, .tms_o, .tdi_o,
    .tdo_smp_o(tdo_smp), .ack_o(ack)
  );
endmodule

// File: tb/tb_jtag_idcode_reader.sv
`timescale 1ns/1ps
module tb_jtag_idcode_reader;
  localparam int MAX_DEV = 8;
  localparam int IR_FILL = 64;

  typedef enum logic [3:0] {
    TLR, RTI, SDS, CDR, SHDR, E1DR, PDR, E2DR, UDR,
    SIS, CIR, SHIR, E1IR, PIR, E2IR, UIR
  } tap_e;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] index = '0;
  logic tck, tms, tdi, tdo, busy, done, bad, suspect;
  logic [31:0] id;

  int nchk = 0, nfail = 0, cycles = 0;

  // behavioural chain
  int          ndev = 0;
  int          ir_len [MAX_DEV];
  logic [31:0] idc    [MAX_DEV];
  bit          byp    [MAX_DEV];
  bit          q[$];
  tap_e        ts = TLR;
  logic        tdo_r = 1'b0;

  always #2 clk = ~clk;

  assign tdo = (ndev == 0) ? tdi : tdo_r;

  jtag_idcode_reader #(.MAX_DEV(MAX_DEV), .IR_FILL(IR_FILL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .index_i(index),
    .tdo_i(tdo), .tck_o(tck), .tms_o(tms), .tdi_o(tdi),
    .busy_o(busy), .done_o(done), .id_o(id),
    .bad_index_o(bad), .suspect_o(suspect)
  );

  function automatic tap_e tap_next(tap_e s, logic t);
    case (s)
      TLR:  return t ? TLR  : RTI;
      RTI:  return t ? SDS  : RTI;
      SDS:  return t ? SIS  : CDR;
      CDR:  return t ? E1DR : SHDR;
      SHDR: return t ? E1DR : SHDR;
      E1DR: return t ? UDR  : PDR;
      PDR:  return t ? E2DR : PDR;
      E2DR: return t ? UDR  : SHDR;
      UDR:  return t ? SDS  : RTI;
      SIS:  return t ? TLR  : CIR;
      CIR:  return t ? E1IR : SHIR;
      SHIR: return t ? E1IR : SHIR;
      E1IR: return t ? UIR  : PIR;
      PIR:  return t ? E2IR : PIR;
      E2IR: return t ? UIR  : SHIR;
      default: return t ? SDS : RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    bit dropped;
    int off;
    bit all1;
    case (ts)
      CIR: begin
        q.delete();
        for (int d = 0; d < ndev; d++)
          for (int b = 0; b < ir_len[d]; b++) q.push_back(b == 0);
      end
      SHIR, SHDR: begin
        q.push_back(tdi);
        dropped = q.pop_front();
      end
      UIR: begin
        off = 0;
        for (int d = 0; d < ndev; d++) begin
          all1 = 1'b1;
          for (int b = 0; b < ir_len[d]; b++) if (!q[off + b]) all1 = 1'b0;
          byp[d] = all1;
          off += ir_len[d];
        end
      end
      CDR: begin
        q.delete();
        for (int d = 0; d < ndev; d++)
          if (byp[d]) q.push_back(1'b0);
          else for (int b = 0; b < 32; b++) q.push_back(idc[d][b]);
      end
      default: ;
    endcase
    ts = tap_next(ts, tms);
    if (ts == TLR) for (int d = 0; d < MAX_DEV; d++) byp[d] = 1'b0;
    tdo_r = (q.size() > 0) ? q[0] : 1'b0;
  end

  // R2 pin timing monitor
  int r2_err = 0, low_run = 0;
  logic p_tck = 1'b0, p_tms = 1'b0, p_tdi = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tck && p_tck) r2_err++;
      if (tck && !p_tck && low_run < 3) r2_err++;
      if (tck && p_tck && (tms != p_tms || tdi != p_tdi)) r2_err++;
      low_run = tck ? 0 : low_run + 1;
    end
    p_tck = tck; p_tms = tms; p_tdi = tdi;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= 190000) begin
        nfail++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        summary();
      end
    end
  end

  task automatic set_chain(input int n);
    ndev = n;
    for (int d = 0; d < MAX_DEV; d++) begin
      ir_len[d] = 2 + int'($urandom % 7);
      idc[d]    = $urandom | 32'h1;
    end
  endtask

  task automatic do_run(input int idx, input bit poke, input int alt, input string tag);
    bit          exp_bad;
    logic [31:0] exp_id;
    bit          got;
    @(negedge clk); start = 1'b1; index = 3'(idx);
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R3 busy after start", 32'(busy), 32'h1);
    if (poke) begin
      repeat (50) @(negedge clk);
      start = 1'b1; index = 3'(alt);
      @(negedge clk); start = 1'b0;
    end
    got = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
    end
    chk(got, "R9 done seen", 32'(got), 32'h1);
    exp_bad = idx >= ((ndev > MAX_DEV) ? MAX_DEV : ndev);
    exp_id  = exp_bad ? 32'h0 : idc[idx];
    chk(bad == exp_bad, "R4/R5 bad_index", 32'(bad), 32'(exp_bad));
    chk(id == exp_id, tag, id, exp_id);
    chk(suspect == (!exp_bad && !exp_id[0]), "R7 suspect", 32'(suspect), 32'(!exp_bad && !exp_id[0]));
    chk(ts == RTI, "R8 tap state", 32'(ts), 32'(RTI));
    chk(busy == 1'b0, "R9 busy low at done", 32'(busy), 32'h0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", 32'(done), 32'h0);
    repeat (10) @(negedge clk);
    chk(id == exp_id && bad == exp_bad, "R9 results held", id, exp_id);
  endtask

  initial begin
    int n, ix;
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    chk(!tck && !busy && !done && !bad && !suspect && id == 32'h0, "R1 reset state",
        {tck, busy, done, bad, suspect, id[26:0]}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    set_chain(1); do_run(0, 1'b0, 0, "R6 single device");
    set_chain(3); do_run(2, 1'b0, 0, "R6 last device");
    set_chain(3); do_run(3, 1'b0, 0, "R5 one past end");
    set_chain(0); do_run(0, 1'b0, 0, "R10 empty chain");
    set_chain(0); do_run(5, 1'b0, 0, "R10 empty chain idx5");
    set_chain(2); idc[1][0] = 1'b0; do_run(1, 1'b0, 0, "R7 id value");
    set_chain(4); do_run(1, 1'b1, 3, "R3 start ignored while busy");
    set_chain(MAX_DEV);
    for (int d = 0; d < MAX_DEV; d++) ir_len[d] = IR_FILL / MAX_DEV;
    do_run(MAX_DEV - 1, 1'b0, 0, "R11 full chain");
    for (int k = 0; k < 10; k++) begin
      n  = 1 + int'($urandom % 6);
      ix = int'($urandom % MAX_DEV);
      set_chain(n);
      if ($urandom % 4 == 0) idc[ix][0] = 1'b0;
      do_run(ix, 1'b0, 0, "R6 random");
    end
    chk(r2_err == 0, "R2 tck timing", 32'(r2_err), 32'h0);
    summary();
  end
endmodule